// File: doc/BRIEF.md
# Decode-Stage Branch Resolver and Fetch Redirect

This block sits in the decode stage of a five-stage in-order pipeline and decides where instruction fetch goes next. A branch in decode compares one register operand against zero, and a dedicated adder in the same stage forms the taken target from the decode-stage sequential address plus a signed offset. Because both results exist one stage after fetch, a taken branch costs at most one fetch slot instead of three.

The block owns the fetch PC register and the IF/ID instruction register. On every unstalled cycle it picks the next fetch address and loads the instruction just fetched into IF/ID. When the instruction fetched behind a branch must not execute, it loads a canonical no-op instead. A build-time parameter selects the control-transfer policy. The delayed policy always executes the one slot after the branch. The squash policy predicts not-taken and discards the wrong-path fetch on a taken branch. The cancelling policy executes the slot only if the branch resolves the way its hint bit predicted.

Top module: `br_nextpc_unit`

## Requirements
- R1: While reset is asserted, the fetch PC output equals `RESET_PC` and the IF/ID output equals `NOP_INSN`.
- R2: The branch kind input is encoded as 00 no branch, 01 branch if the register is zero, 10 branch if the register is non-zero, and 11 always branch. `taken_o` is high on an unstalled cycle exactly when that condition holds, and is never high for kind 00.
- R3: On a taken branch, `next_pc_o` equals the decode sequential address plus the sign-extended offset, computed modulo 2^XLEN.
- R4: On an unstalled cycle without a taken branch, `next_pc_o` equals the fetch PC plus ILEN/8, wrapping modulo 2^XLEN.
- R5: After an unstalled cycle, the fetch PC holds the previous `next_pc_o`. IF/ID then holds the previously fetched instruction if the slot was not killed, and `NOP_INSN` if it was.
- R6: With POLICY 0 (delayed), `kill_o` is never asserted, so the instruction after a branch always enters IF/ID.
- R7: With POLICY 1 (squash), `kill_o` is asserted exactly when `taken_o` is asserted.
- R8: With POLICY 2 (cancelling), `kill_o` is asserted on an unstalled cycle exactly when the kind is not 00 and the outcome differs from the hint (hint 1 means predicted taken).
- R9: While the stall input is high, `next_pc_o` equals the fetch PC, `kill_o` and `taken_o` are low, and the fetch PC and IF/ID hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Freeze decode and fetch for this cycle |
| br_kind_i | input | 2 | Decoded branch kind (see R2) |
| br_hint_i | input | 1 | Predicted direction for cancelling branches |
| rs_val_i | input | XLEN | Register operand tested against zero |
| dec_pc4_i | input | XLEN | Sequential address of the instruction in decode |
| br_ofs_i | input | OFS_W | Signed branch offset |
| fetch_insn_i | input | ILEN | Instruction returned for the current fetch PC |
| fetch_pc_o | output | XLEN | Current fetch PC |
| next_pc_o | output | XLEN | Fetch address for the next cycle |
| kill_o | output | 1 | Replace the current fetch with a no-op in IF/ID |
| taken_o | output | 1 | Branch in decode resolves taken |
| ifid_insn_o | output | ILEN | IF/ID instruction register |

## Verification
All three policies run side by side on identical stimulus, and each is compared against its own behavioural model on every cycle. Directed patterns use a zero register, a register of one, and an all-ones register with both zero-test kinds. These separate a true zero test from a sign or low-bit test. Offsets of 0x7FFF, 0x8000 and 0xFFFF, paired with sequential addresses near the top of the address space, separate sign extension from zero extension and show whether wrap-around is handled. Long random runs mix stalls with branches, hints that agree or disagree with the outcome, and back-to-back branches. These runs show whether a stall really freezes state and whether the kill decision follows the outcome, the hint or neither.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {
      BR_NONE   = 2'b00,
      BR_EQZ    = 2'b01,
      BR_NEZ    = 2'b10,
      BR_ALWAYS = 2'b11
   } br_kind_e;

   localparam int POL_DELAY  = 0;
   localparam int POL_SQUASH = 1;
   localparam int POL_CANCEL = 2;
endpackage

// File: rtl/br_zero_test.sv
module br_zero_test
   import br_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  br_kind_e          kind,
   input  logic [XLEN-1:0]   rs_val,
   output logic              is_branch,
   output logic              cond
);
   logic is_zero;

   assign is_zero   = (rs_val == '0);
   assign is_branch = (kind != BR_NONE);

   always_comb begin
      unique case (kind)
         BR_EQZ:    cond = is_zero;
         BR_NEZ:    cond = !is_zero;
         BR_ALWAYS: cond = 1'b1;
         default:   cond = 1'b0;
      endcase
   end
endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
   parameter int XLEN  = 32,
   parameter int OFS_W = 16
) (
   input  logic [XLEN-1:0]  base,
   input  logic [OFS_W-1:0] ofs,
   output logic [XLEN-1:0]  target
);
   localparam int EXT_W = XLEN - OFS_W;

   logic [XLEN-1:0] ofs_ext;

   assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
   assign target  = base + ofs_ext;
endmodule

// File: rtl/br_redirect.sv
module br_redirect
   import br_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int POLICY = POL_SQUASH
) (
   input  logic            stall,
   input  logic            is_branch,
   input  logic            cond,
   input  logic            hint,
   input  logic [XLEN-1:0] hold_pc,
   input  logic [XLEN-1:0] seq_pc,
   input  logic [XLEN-1:0] target,
   output logic [XLEN-1:0] next_pc,
   output logic            kill,
   output logic            taken
);
   localparam logic KILL_ON_TAKEN = (POLICY == POL_SQUASH);
   localparam logic KILL_ON_MISS  = (POLICY == POL_CANCEL);

   logic miss;

   assign taken = !stall && cond;
   assign miss  = !stall && is_branch && (cond != hint);

   generate
      if (POLICY == POL_DELAY) begin : g_delay
         assign kill = 1'b0 & (taken | miss);
      end else begin : g_kill
         assign kill = (KILL_ON_TAKEN & taken) | (KILL_ON_MISS & miss);
      end
   endgenerate

   always_comb begin
      if (stall)      next_pc = hold_pc;
      else if (taken) next_pc = target;
      else            next_pc = seq_pc;
   end
endmodule

// File: rtl/br_nextpc_unit.sv
module br_nextpc_unit
   import br_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter int              OFS_W    = 16,
   parameter int              ILEN     = 32,
   parameter int              POLICY   = POL_SQUASH,
   parameter logic [XLEN-1:0] RESET_PC = '0,
   parameter logic [ILEN-1:0] NOP_INSN = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall_i,
   input  logic [1:0]       br_kind_i,
   input  logic             br_hint_i,
   input  logic [XLEN-1:0]  rs_val_i,
   input  logic [XLEN-1:0]  dec_pc4_i,
   input  logic [OFS_W-1:0] br_ofs_i,
   input  logic [ILEN-1:0]  fetch_insn_i,
   output logic [XLEN-1:0]  fetch_pc_o,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             kill_o,
   output logic             taken_o,
   output logic [ILEN-1:0]  ifid_insn_o
);
   localparam int STEP = ILEN / 8;

   generate
      if (OFS_W < 2 || OFS_W >= XLEN) begin : g_bad_ofs
         $error("br_nextpc_unit: OFS_W must lie in 2..XLEN-1");
      end
      if (ILEN < 8 || (ILEN % 8) != 0) begin : g_bad_ilen
         $error("br_nextpc_unit: ILEN must be a whole number of bytes");
      end
      if (POLICY < POL_DELAY || POLICY > POL_CANCEL) begin : g_bad_pol
         $error("br_nextpc_unit: POLICY must be 0, 1 or 2");
      end
   endgenerate

   logic [XLEN-1:0] pc_q;
   logic [ILEN-1:0] ifid_q;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] target;
   logic            is_branch;
   logic            cond;

   assign seq_pc = pc_q + XLEN'(STEP);

   br_zero_test #(.XLEN(XLEN)) u_zero (
      .kind      (br_kind_e'(br_kind_i)),
      .rs_val    (rs_val_i),
      .is_branch (is_branch),
      .cond      (cond)
   );

   br_target_add #(.XLEN(XLEN), .OFS_W(OFS_W)) u_tgt (
      .base   (dec_pc4_i),
      .ofs    (br_ofs_i),
      .target (target)
   );

   br_redirect #(.XLEN(XLEN), .POLICY(POLICY)) u_redir (
      .stall     (stall_i),
      .is_branch (is_branch),
      .cond      (cond),
      .hint      (br_hint_i),
      .hold_pc   (pc_q),
      .seq_pc    (seq_pc),
      .target    (target),
      .next_pc   (next_pc_o),
      .kill      (kill_o),
      .taken     (taken_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_PC;
         ifid_q <= NOP_INSN;
      end else if (!stall_i) begin
         pc_q   <= next_pc_o;
         ifid_q <= kill_o ? NOP_INSN : fetch_insn_i;
      end
   end

   assign fetch_pc_o  = pc_q;
   assign ifid_insn_o = ifid_q;
endmodule

// File: rtl/br_nextpc_chk.sv
module br_nextpc_chk #(
   parameter int              XLEN     = 32,
   parameter int              ILEN     = 32,
   parameter int              POLICY   = 1,
   parameter logic [ILEN-1:0] NOP_INSN = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            stall_i,
   input logic [1:0]      br_kind_i,
   input logic            br_hint_i,
   input logic [XLEN-1:0] fetch_pc_o,
   input logic [XLEN-1:0] next_pc_o,
   input logic            kill_o,
   input logic            taken_o,
   input logic [ILEN-1:0] ifid_insn_o
);
   // R9: a stall freezes fetch state
   a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> (fetch_pc_o == $past(fetch_pc_o)) && (ifid_insn_o == $past(ifid_insn_o)));

   // R9: a stall suppresses redirect and kill
   a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> !kill_o && !taken_o && (next_pc_o == fetch_pc_o));

   // R5: the fetch PC follows the selected next address
   a_r5_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !stall_i |=> fetch_pc_o == $past(next_pc_o));

   // R5: a killed slot shows up as a no-op in IF/ID
   a_r5_nop_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o |=> ifid_insn_o == NOP_INSN);

   // R2: no branch, no redirect
   a_r2_none_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (br_kind_i == 2'b00) |-> !taken_o);

   // R6: delayed policy never discards the slot
   a_r6_delay_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == 0) |-> !kill_o);

   // R7: squash policy kills only on a taken branch
   a_r7_kill_iff_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == 1) |-> (kill_o == taken_o));

   // R8: cancelling policy kills only on a wrong hint
   a_r8_kill_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (POLICY == 2 && kill_o) |-> (br_kind_i != 2'b00) && (taken_o != br_hint_i));
endmodule

bind br_nextpc_unit br_nextpc_chk #(
   .XLEN(XLEN), .ILEN(ILEN), .POLICY(POLICY), .NOP_INSN(NOP_INSN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stall_i     (stall_i),
   .br_kind_i   (br_kind_i),
   .br_hint_i   (br_hint_i),
   .fetch_pc_o  (fetch_pc_o),
   .next_pc_o   (next_pc_o),
   .kill_o      (kill_o),
   .taken_o     (taken_o),
   .ifid_insn_o (ifid_insn_o)
);

// File: tb/tb_br_nextpc_unit.sv
module tb_br_nextpc_unit;
   localparam logic [31:0] RST_PC = 32'h0000_1000;
   localparam logic [31:0] NOP    = 32'h0000_0013;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic [1:0]  kind = 2'b00;
   logic        hint = 1'b0;
   logic [31:0] rs = '0;
   logic [31:0] dpc4 = '0;
   logic [15:0] ofs = '0;
   logic [31:0] insn = '0;

   logic [31:0] o_pc   [3];
   logic [31:0] o_npc  [3];
   logic        o_kill [3];
   logic        o_tk   [3];
   logic [31:0] o_ifid [3];

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   for (genvar p = 0; p < 3; p++) begin : g_pol
      br_nextpc_unit #(
         .XLEN(32), .OFS_W(16), .ILEN(32), .POLICY(p),
         .RESET_PC(RST_PC), .NOP_INSN(NOP)
      ) dut (
         .clk(clk), .rst_n(rst_n), .stall_i(stall), .br_kind_i(kind),
         .br_hint_i(hint), .rs_val_i(rs), .dec_pc4_i(dpc4), .br_ofs_i(ofs),
         .fetch_insn_i(insn), .fetch_pc_o(o_pc[p]), .next_pc_o(o_npc[p]),
         .kill_o(o_kill[p]), .taken_o(o_tk[p]), .ifid_insn_o(o_ifid[p])
      );
   end

   logic [31:0] m_pc   [3];
   logic [31:0] m_ifid [3];

   task automatic chk(string rq, int p, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s policy=%0d %s actual=%h expected=%h", rq, p, what, act, exp);
      end
   endtask

   function automatic string pol_req(int p);
      if (p == 0) return "R6";
      if (p == 1) return "R7";
      return "R8";
   endfunction

   // Drive one cycle, compare against the model, advance the model.
   task automatic step(logic s, logic [1:0] k, logic h, logic [31:0] r,
                       logic [31:0] d, logic [15:0] o, logic [31:0] i);
      logic        tk;
      logic [31:0] tgt;
      logic [31:0] npc;
      logic        kl;
      stall = s; kind = k; hint = h; rs = r; dpc4 = d; ofs = o; insn = i;
      #1;
      case (k)
         2'b01:   tk = (r == 32'd0);
         2'b10:   tk = (r != 32'd0);
         2'b11:   tk = 1'b1;
         default: tk = 1'b0;
      endcase
      if (s) tk = 1'b0;
      tgt = d + {{16{o[15]}}, o};
      for (int p = 0; p < 3; p++) begin
         if (s)       npc = m_pc[p];
         else if (tk) npc = tgt;
         else         npc = m_pc[p] + 32'd4;
         if (s)           kl = 1'b0;
         else if (p == 0) kl = 1'b0;
         else if (p == 1) kl = tk;
         else             kl = (k != 2'b00) && (tk != h);
         chk(s ? "R9" : "R2", p, "taken", {31'd0, o_tk[p]}, {31'd0, tk});
         chk(s ? "R9" : (tk ? "R3" : "R4"), p, "next_pc", o_npc[p], npc);
         chk(s ? "R9" : pol_req(p), p, "kill", {31'd0, o_kill[p]}, {31'd0, kl});
         chk("R5", p, "fetch_pc", o_pc[p], m_pc[p]);
         chk("R5", p, "ifid", o_ifid[p], m_ifid[p]);
         if (!s) begin
            m_pc[p]   = npc;
            m_ifid[p] = kl ? NOP : i;
         end
      end
      @(negedge clk);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
         chk("R1", p, "reset fetch_pc", o_pc[p], RST_PC);
         chk("R1", p, "reset ifid", o_ifid[p], NOP);
         m_pc[p]   = RST_PC;
         m_ifid[p] = NOP;
      end
      rst_n = 1'b1;

      // R2/R3/R4 corners: zero tests on 0, 1 and all ones
      step(0, 2'b00, 0, 32'd0,        32'h0000_2000, 16'h0040, 32'hA000_0001);
      step(0, 2'b01, 0, 32'd0,        32'h0000_2000, 16'h0040, 32'hA000_0002);
      step(0, 2'b01, 0, 32'd1,        32'h0000_2000, 16'h0040, 32'hA000_0003);
      step(0, 2'b01, 1, 32'hFFFF_FFFF, 32'h0000_2000, 16'h0040, 32'hA000_0004);
      step(0, 2'b10, 1, 32'd0,        32'h0000_3000, 16'h0010, 32'hA000_0005);
      step(0, 2'b10, 1, 32'd1,        32'h0000_3000, 16'h0010, 32'hA000_0006);
      step(0, 2'b10, 0, 32'h8000_0000, 32'h0000_3000, 16'h0010, 32'hA000_0007);
      step(0, 2'b11, 0, 32'd5,        32'h0000_4000, 16'h0000, 32'hA000_0008);
      // R3: sign extension and wrap
      step(0, 2'b11, 1, 32'd0, 32'h0000_4000, 16'h8000, 32'hA000_0009);
      step(0, 2'b11, 1, 32'd0, 32'h0000_0004, 16'hFFFF, 32'hA000_000A);
      step(0, 2'b11, 1, 32'd0, 32'hFFFF_FFF0, 16'h7FFF, 32'hA000_000B);
      // R4: sequential wrap from the top of the address space
      step(0, 2'b11, 1, 32'd0, 32'hFFFF_FFF8, 16'h0000, 32'hA000_000C);
      step(0, 2'b00, 0, 32'd0, 32'd0, 16'd0, 32'hA000_000D);
      step(0, 2'b00, 0, 32'd0, 32'd0, 16'd0, 32'hA000_000E);
      // R9: stall with a taken branch pending, then release
      step(1, 2'b11, 0, 32'd0, 32'h0000_5000, 16'h0100, 32'hA000_000F);
      step(1, 2'b01, 0, 32'd0, 32'h0000_5000, 16'h0100, 32'hA000_0010);
      step(0, 2'b01, 0, 32'd0, 32'h0000_5000, 16'h0100, 32'hA000_0011);
      // back-to-back branches
      step(0, 2'b10, 1, 32'd7, 32'h0000_6000, 16'hFFF0, 32'hA000_0012);
      step(0, 2'b01, 1, 32'd7, 32'h0000_6000, 16'hFFF0, 32'hA000_0013);

      for (int n = 0; n < 4000; n++) begin
         logic [31:0] rv;
         rv = ($urandom % 2 == 0) ? 32'd0 : $urandom;
         step(($urandom % 6) == 0, 2'($urandom), 1'($urandom), rv,
              $urandom, 16'($urandom), $urandom);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule